// File: doc/BRIEF.md
# Pager Decoder Option-Bit Loader

This block sits on the host side of a pager-protocol decoder and loads its configuration. Software presents a 192-bit option vector and pulses `start`. The block then holds the decoder in reset for a guard interval, waits a second guard interval, and shifts every option bit out over a two-wire serial link made of a clock and data. After a final guard interval it enables the decoder with a falling edge on the enable line.

All guard intervals are timed by a free-running millisecond tick that comes from outside the block. The serial clock half-period is a count of system clock cycles. Data is updated in the cycle the serial clock falls, so the decoder can sample it on the rising edge. The vector is captured when the load starts, so later changes to the input do not affect a load in progress.

Top module: `optbit_loader`

## Requirements
- R1: After reset, busy, done, dec_rst, sclk, sdata and dec_on are all 0.
- R2: A start seen while idle makes busy, dec_rst and dec_on 1 on the next cycle, and captures the option vector at that edge.
- R3: dec_rst stays high until the (GAP_MS+1)-th ms_tick after start, so the reset lasts at least GAP_MS full tick periods; it falls on the edge that follows that tick.
- R4: After dec_rst falls, sclk stays low until GAP_MS+1 further ticks have passed and then for HALF_CYC more cycles, so at least GAP_MS tick periods pass before the first rising edge.
- R5: Each load produces exactly NBITS rising edges on sclk.
- R6: The k-th rising edge of sclk (k counted from 0) carries bit k of the captured vector on sdata, so bit 0 goes first.
- R7: sclk stays low and then high for HALF_CYC cycles each per bit. While busy, sdata changes only in the cycle in which sclk falls, apart from the capture at start.
- R8: After the last falling edge of sclk, the block waits for GAP_MS+1 ticks. dec_on then falls and done is 1 for exactly that one cycle, in the same cycle in which busy returns to 0. After the load, sdata is 0.
- R9: start is ignored while busy. A change to opts during a load has no effect on the bits that are shifted out.
- R10: dec_on stays high for the whole time busy is high, and stays low while the block is idle after a completed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| opts | input | NBITS | Option vector; bit 0 is sent first |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse when the decoder is enabled |
| dec_rst | output | 1 | Decoder reset, active high |
| sclk | output | 1 | Serial clock; data is sampled on its rising edge |
| sdata | output | 1 | Serial data |
| dec_on | output | 1 | Decoder enable line; a falling edge enables the decoder |

## Verification
The bench keeps NBITS at its full 192 but uses a short serial half-period (HALF_CYC=3) and a millisecond tick that fires every 40 clock cycles. This makes one complete load take about 1,500 cycles, so several loads with different bit patterns fit in one run. These settings also bring every phase boundary, the last-bit-to-gap transition and the done pulse within reach of the per-cycle reference model. Mid-load start pulses and changes to opts are used to check that a load in progress is left alone.

// File: rtl/optbit_loader.sv
module optbit_loader #(
  parameter int NBITS    = 192,
  parameter int HALF_CYC = 100,
  parameter int GAP_MS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ms_tick,
  input  logic [NBITS-1:0] opts,
  output logic             busy,
  output logic             done,
  output logic             dec_rst,
  output logic             sclk,
  output logic             sdata,
  output logic             dec_on
);
  localparam int TW = $clog2(GAP_MS + 2);
  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int BW = $clog2(NBITS);
  localparam logic [TW-1:0] TLAST = TW'(GAP_MS);
  localparam logic [HW-1:0] HLAST = HW'(HALF_CYC - 1);
  localparam logic [BW-1:0] BLAST = BW'(NBITS - 1);

  typedef enum logic [2:0] {IDLE, HOLD, GAP_A, SHIFT, GAP_B} ph_t;

  ph_t             ph;
  logic [TW-1:0]   tcnt;
  logic [HW-1:0]   hcnt;
  logic [BW-1:0]   bidx;
  logic [NBITS-1:0] sh;
  logic            sclk_q, on_q, done_q;

  wire tick_end = ms_tick && (tcnt == TLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= IDLE;
      tcnt   <= '0;
      hcnt   <= '0;
      bidx   <= '0;
      sh     <= '0;
      sclk_q <= 1'b0;
      on_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        IDLE: if (start) begin
          ph   <= HOLD;
          tcnt <= '0;
          sh   <= opts;
          on_q <= 1'b1;
        end
        HOLD, GAP_A: if (ms_tick) begin
          if (tick_end) begin
            tcnt <= '0;
            ph   <= (ph == HOLD) ? GAP_A : SHIFT;
            hcnt <= '0;
            bidx <= '0;
            sclk_q <= 1'b0;
          end else tcnt <= tcnt + 1'b1;
        end
        SHIFT: begin
          if (hcnt == HLAST) begin
            hcnt <= '0;
            if (!sclk_q) sclk_q <= 1'b1;
            else begin
              sclk_q <= 1'b0;
              sh     <= sh >> 1;
              if (bidx == BLAST) begin
                ph   <= GAP_B;
                tcnt <= '0;
              end else bidx <= bidx + 1'b1;
            end
          end else hcnt <= hcnt + 1'b1;
        end
        GAP_B: if (ms_tick) begin
          if (tick_end) begin
            ph     <= IDLE;
            on_q   <= 1'b0;
            done_q <= 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  assign busy    = (ph != IDLE);
  assign done    = done_q;
  assign dec_rst = (ph == HOLD);
  assign sclk    = sclk_q;
  assign sdata   = sh[0];
  assign dec_on  = on_q;
endmodule

module optbit_loader_chk #(
  parameter int NBITS = 192
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ms_tick,
  input logic busy,
  input logic done,
  input logic dec_rst,
  input logic sclk,
  input logic sdata,
  input logic dec_on
);
  logic [15:0] rises;
  logic        sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rises  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (!busy) rises <= '0;
      else if (sclk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && dec_rst && dec_on));
  assert_reset_ends_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(dec_rst)) |-> $past(ms_tick));
  assert_bit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises == 16'(NBITS)));
  assert_data_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sdata)) |-> $fell(sclk));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_enable_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dec_on) |-> (done && !busy));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && $past(busy)) |-> !$rose(dec_rst));
  assert_on_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dec_on);
endmodule

bind optbit_loader optbit_loader_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick), .busy(busy),
  .done(done), .dec_rst(dec_rst), .sclk(sclk), .sdata(sdata), .dec_on(dec_on)
);

// File: tb/tb_optbit_loader.sv
module tb_optbit_loader;
  localparam int NBITS = 192;
  localparam int HALF  = 3;
  localparam int GAP   = 2;
  localparam int TICKP = 40;
  localparam int LIMIT = 200000;

  logic clk = 0, rst_n = 0, start = 0, ms_tick = 0;
  logic [NBITS-1:0] opts = '0;
  logic busy, done, dec_rst, sclk, sdata, dec_on;

  optbit_loader #(.NBITS(NBITS), .HALF_CYC(HALF), .GAP_MS(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick), .opts(opts),
    .busy(busy), .done(done), .dec_rst(dec_rst), .sclk(sclk), .sdata(sdata), .dec_on(dec_on));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // tick generator
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == TICKP - 1) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == 0);
  end

  // behavioural reference model
  int mph = 0, mt = 0, mh = 0, mb = NBITS;
  logic msclk = 0, mon = 0, mdone = 0;
  logic [NBITS-1:0] mvec = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mt = 0; mh = 0; mb = NBITS; msclk = 0; mon = 0; mdone = 0;
    end else begin
      mdone = 0;
      case (mph)
        0: if (start) begin mph = 1; mt = 0; mvec = opts; mb = 0; mon = 1; end
        1, 2: if (ms_tick) begin
          if (mt == GAP) begin mph = mph + 1; mt = 0; mh = 0; msclk = 0; end
          else mt = mt + 1;
        end
        3: if (mh == HALF - 1) begin
          mh = 0;
          if (!msclk) msclk = 1;
          else begin
            msclk = 0;
            if (mb == NBITS - 1) begin mph = 4; mt = 0; mb = NBITS; end
            else mb = mb + 1;
          end
        end else mh = mh + 1;
        default: if (ms_tick) begin
          if (mt == GAP) begin mph = 0; mon = 0; mdone = 1; end
          else mt = mt + 1;
        end
      endcase
    end
  end

  // per-cycle comparison plus serial-line monitor
  logic [NBITS-1:0] want = '0, got = '0;
  int nrise = 0, t_rfall = 0, t_first = -1, t_lfall = 0, t_rrise = 0;
  logic psclk = 0, prst = 0;
  always @(negedge clk) begin
    cyc++;
    if (!finished) begin
      logic esd;
      esd = (mph != 0 && mb < NBITS) ? mvec[mb] : 1'b0;
      chk("R2/R9 busy",    32'(busy),    32'(mph != 0));
      chk("R3 dec_rst",    32'(dec_rst), 32'(mph == 1));
      chk("R4/R7 sclk",    32'(sclk),    32'(msclk));
      chk("R6/R7 sdata",   32'(sdata),   32'(esd));
      chk("R10 dec_on",    32'(dec_on),  32'(mon));
      chk("R8 done",       32'(done),    32'(mdone));
      if (rst_n) begin
        if (dec_rst && !prst) t_rrise = cyc;
        if (!dec_rst && prst) begin
          t_rfall = cyc;
          chk("R3 reset width ok", 32'((t_rfall - t_rrise) >= GAP * TICKP), 1);
        end
        if (sclk && !psclk) begin
          if (nrise == 0) begin
            t_first = cyc;
            chk("R4 gap before clocking ok", 32'((t_first - t_rfall) >= GAP * TICKP), 1);
          end
          if (nrise < NBITS) got[nrise] = sdata;
          nrise++;
        end
        if (!sclk && psclk) t_lfall = cyc;
        if (done) begin
          chk("R5 rising edges", 32'(nrise), 32'(NBITS));
          chk("R6 bit order", 32'(got == want), 1);
          chk("R8 gap before enable ok", 32'((cyc - t_lfall) >= GAP * TICKP), 1);
          nrise = 0; got = '0;
        end
      end
      psclk = sclk; prst = dec_rst;
    end
  end

  task automatic wait_done();
    while (!done && !finished) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [NBITS-1:0] v, input bit disturb);
    @(negedge clk);
    opts = v; want = v; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 busy after start", 32'(busy), 1);
    if (disturb) begin
      repeat (200) @(negedge clk);
      opts = ~v; start = 1;          // R9: both must be ignored
      @(negedge clk);
      start = 0;
      repeat (500) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    wait_done();
    chk("R10 dec_on low after load", 32'(dec_on), 0);
    chk("R8 sdata idle", 32'(sdata), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy",   32'(busy), 0);
    chk("R1 dec_on", 32'(dec_on), 0);
    chk("R1 sclk",   32'(sclk), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    load({6{32'hA5C3_0F01}}, 1'b1);
    load({NBITS{1'b1}}, 1'b0);
    load({{(NBITS-1){1'b0}}, 1'b1}, 1'b0);
    load({1'b1, {(NBITS-1){1'b0}}}, 1'b1);
    load({12{16'h1357}}, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 stays idle", 32'(dec_on | busy), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > LIMIT && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule